// File: doc/BRIEF.md
# Chroma Line-Delay Combiner

This block takes a stream of demodulated colour-difference samples (a CB and a CR value per sample) and joins every line with the line stored one line earlier at the same position. Under PAL the two lines are averaged, which cancels the crosstalk that a phase error puts between the two chroma channels. Under NTSC the same averaging acts as an extra vertical filter. Under SECAM, where each line carries only one of the two colour components, the block works as a cross-over switch: one component comes from the current line and the other from the stored line, so that every output line carries both.

A line strobe marks the first sample of each line, and the sample position counts from there. A line-alternation flag sets the SECAM mapping. A per-line bypass flag marks lines, such as vertical-blanking or raw-data lines, that must pass through untouched. A disable input turns the combining off altogether. The line memory is written with every sample that fits in it, whatever the mode, so history is always ready. The output is registered and follows the input by one cycle.

Top module: `chroma_line_combiner`

## Requirements
- R1: While reset is asserted and after its release, out_valid is 0 and out_cb and out_cr are 0 until the first valid sample.
- R2: out_valid equals in_valid delayed by one cycle, and out_cb and out_cr hold their values in cycles that follow a cycle with in_valid low.
- R3: With std_sel = 0 (PAL), each output component is (current + stored + 1) >> 1, where the stored value is the same component at the same sample position on the previous line. CB and CR are averaged independently.
- R4: With std_sel = 1 (NTSC), the output is the same rounded average as in R3.
- R5: With std_sel = 2 (SECAM), alt_line is sampled with line_start and held for the line. If it is 0, out_cb is the current CB and out_cr is the stored CR. If it is 1, out_cb is the stored CB and out_cr is the current CR.
- R6: With dl_off = 1, both components pass through unchanged.
- R7: line_bypass is sampled with line_start. When it is 1, every sample of that line passes through unchanged.
- R8: The line memory is written on every valid sample whose position is below LINE_LEN, including on disabled, bypassed and pass-through lines. The next combined line therefore uses that data.
- R9: Samples before the second line_start after reset pass through unchanged, because no previous line is stored yet.
- R10: Samples at position LINE_LEN or beyond within a line pass through unchanged and are not stored.
- R11: With std_sel = 3, both components pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample is present this cycle |
| line_start | input | 1 | This sample is position 0 of a new line; valid only together with in_valid |
| std_sel | input | 2 | 0 PAL, 1 NTSC, 2 SECAM, 3 pass-through |
| alt_line | input | 1 | Line-alternation flag for the SECAM mapping, sampled with line_start |
| dl_off | input | 1 | 1 switches combining off |
| line_bypass | input | 1 | Pass-through request for the line, sampled with line_start |
| in_cb | input | DW | Current CB sample |
| in_cr | input | DW | Current CR sample |
| out_valid | output | 1 | Output sample present |
| out_cb | output | DW | Combined CB |
| out_cr | output | DW | Combined CR |

## Verification
The hardest case to reach is a combined line whose stored data was written while processing was off. The stored data can come from a disabled line, a bypassed line, a line longer than the memory, or a shorter line that leaves older entries in place. The stimulus table therefore chains lines so that each mode switch is followed by a combining line, and a bench-side model of the previous line supplies the expected averages and cross-over values. A reset in the middle of the run then checks that history is discarded and that the next line passes through.

// File: rtl/chroma_line_combiner.sv
module chroma_line_combiner #(
  parameter int DW       = 8,
  parameter int LINE_LEN = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          line_start,
  input  logic [1:0]    std_sel,
  input  logic          alt_line,
  input  logic          dl_off,
  input  logic          line_bypass,
  input  logic [DW-1:0] in_cb,
  input  logic [DW-1:0] in_cr,
  output logic          out_valid,
  output logic [DW-1:0] out_cb,
  output logic [DW-1:0] out_cr
);

  localparam int AW = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;
  localparam logic [AW:0] LEN = (AW+1)'(LINE_LEN);
  localparam logic [1:0] STD_PAL   = 2'd0;
  localparam logic [1:0] STD_NTSC  = 2'd1;
  localparam logic [1:0] STD_SECAM = 2'd2;

  logic [AW:0]   wp_q, idx;
  logic          in_range;
  logic          byp_q, alt_q, seen_q, hist_q;
  logic          byp, alt, hist;
  logic [DW-1:0] mem_cb [LINE_LEN];
  logic [DW-1:0] mem_cr [LINE_LEN];
  logic [DW-1:0] d_cb, d_cr;
  logic [DW:0]   sum_cb, sum_cr;
  logic          pass;
  logic [DW-1:0] nx_cb, nx_cr;

  assign idx      = line_start ? '0 : wp_q;
  assign in_range = idx < LEN;
  assign byp      = line_start ? line_bypass : byp_q;
  assign alt      = line_start ? alt_line : alt_q;
  assign hist     = line_start ? seen_q : hist_q;

  assign d_cb = mem_cb[idx[AW-1:0]];
  assign d_cr = mem_cr[idx[AW-1:0]];

  assign sum_cb = {1'b0, in_cb} + {1'b0, d_cb} + 1'b1;
  assign sum_cr = {1'b0, in_cr} + {1'b0, d_cr} + 1'b1;

  assign pass = dl_off | byp | ~hist | ~in_range;

  always_comb begin
    nx_cb = in_cb;
    nx_cr = in_cr;
    if (!pass) begin
      case (std_sel)
        STD_PAL, STD_NTSC: begin
          nx_cb = sum_cb[DW:1];
          nx_cr = sum_cr[DW:1];
        end
        STD_SECAM: begin
          if (alt) nx_cb = d_cb;
          else     nx_cr = d_cr;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_range) begin
      mem_cb[idx[AW-1:0]] <= in_cb;
      mem_cr[idx[AW-1:0]] <= in_cr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q      <= '0;
      byp_q     <= 1'b0;
      alt_q     <= 1'b0;
      seen_q    <= 1'b0;
      hist_q    <= 1'b0;
      out_valid <= 1'b0;
      out_cb    <= '0;
      out_cr    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        wp_q   <= in_range ? idx + 1'b1 : LEN;
        byp_q  <= byp;
        alt_q  <= alt;
        hist_q <= hist;
        if (line_start) seen_q <= 1'b1;
        out_cb <= nx_cb;
        out_cr <= nx_cr;
      end
    end
  end

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_cb) && $stable(out_cr)));
  assert_off_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dl_off) |=> (out_cb == $past(in_cb) && out_cr == $past(in_cr)));
  assert_secam_one_current_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && std_sel == STD_SECAM) |=>
      (out_cb == $past(in_cb) || out_cr == $past(in_cr)));
  assert_avg_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && std_sel == STD_PAL && in_cb == d_cb && in_cr == d_cr) |=>
      (out_cb == $past(in_cb) && out_cr == $past(in_cr)));
  assert_std3_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && std_sel == 2'd3) |=> (out_cb == $past(in_cb) && out_cr == $past(in_cr)));

endmodule

// File: tb/sim_chroma_line_combiner.sv
module sim_chroma_line_combiner;

  localparam int LEN = 16;
  localparam int NV  = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, line_start = 1'b0, alt_line = 1'b0;
  logic       dl_off = 1'b0, line_bypass = 1'b0;
  logic [1:0] std_sel = 2'd0;
  logic [7:0] in_cb = '0, in_cr = '0;
  logic       out_valid;
  logic [7:0] out_cb, out_cr;

  always #2 clk = ~clk;

  chroma_line_combiner #(.DW(8), .LINE_LEN(LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .line_start(line_start),
    .std_sel(std_sel), .alt_line(alt_line), .dl_off(dl_off),
    .line_bypass(line_bypass), .in_cb(in_cb), .in_cr(in_cr),
    .out_valid(out_valid), .out_cb(out_cb), .out_cr(out_cr));

  // {std[25:24], alt[23], off[22], byp[21], nsamp[20:16], cb_base[15:8], cr_base[7:0]}
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 5'd16, 8'h10, 8'h80},
    {2'd0, 1'b0, 1'b0, 1'b0, 5'd16, 8'h40, 8'hC0},
    {2'd1, 1'b0, 1'b0, 1'b0, 5'd16, 8'hF0, 8'h05},
    {2'd2, 1'b0, 1'b0, 1'b0, 5'd16, 8'h22, 8'h99},
    {2'd2, 1'b1, 1'b0, 1'b0, 5'd16, 8'h77, 8'h31},
    {2'd0, 1'b0, 1'b1, 1'b0, 5'd16, 8'hA0, 8'h0A},
    {2'd0, 1'b0, 1'b0, 1'b0, 5'd16, 8'h03, 8'hFE},
    {2'd0, 1'b0, 1'b0, 1'b1, 5'd16, 8'h5A, 8'hA5},
    {2'd1, 1'b0, 1'b0, 1'b0, 5'd16, 8'h81, 8'h7F},
    {2'd0, 1'b0, 1'b0, 1'b0, 5'd18, 8'h11, 8'hEE},
    {2'd0, 1'b0, 1'b0, 1'b0, 5'd16, 8'hC3, 8'h3C},
    {2'd3, 1'b0, 1'b0, 1'b0, 5'd16, 8'h66, 8'h44},
    {2'd0, 1'b0, 1'b0, 1'b0, 5'd10, 8'h09, 8'h90},
    {2'd0, 1'b0, 1'b0, 1'b0, 5'd16, 8'hE1, 8'h1E}
  };

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  int m_cb [LEN];
  int m_cr [LEN];
  int m_wp = 0;
  bit m_seen = 1'b0, m_hist = 1'b0, prev_dis = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // assumes called at a falling edge; returns at the next falling edge
  task automatic send(input bit ls, input logic [1:0] sd, input bit al, input bit off,
                      input bit byp, input int cb, input int cr, input bit dis_before);
    int idx, ecb, ecr;
    bit pass;
    string tag;
    idx = ls ? 0 : m_wp;
    if (ls) m_hist = m_seen;
    pass = off || byp || !m_hist || idx >= LEN || sd == 2'd3;
    ecb = cb; ecr = cr;
    if (!pass) begin
      if (sd == 2'd2) begin
        if (al) ecb = m_cb[idx]; else ecr = m_cr[idx];
      end else begin
        ecb = (cb + m_cb[idx] + 1) >> 1;
        ecr = (cr + m_cr[idx] + 1) >> 1;
      end
    end
    if (!m_hist) tag = "R9";
    else if (idx >= LEN) tag = "R10";
    else if (off) tag = "R6";
    else if (byp) tag = "R7";
    else if (sd == 2'd3) tag = "R11";
    else if (sd == 2'd2) tag = "R5";
    else if (dis_before) tag = "R8";
    else if (sd == 2'd0) tag = "R3";
    else tag = "R4";
    in_valid = 1'b1; line_start = ls; std_sel = sd; alt_line = al;
    dl_off = off; line_bypass = byp; in_cb = 8'(cb); in_cr = 8'(cr);
    if (idx < LEN) begin m_cb[idx] = cb; m_cr[idx] = cr; end
    m_wp = (idx < LEN) ? idx + 1 : LEN;
    if (ls) m_seen = 1'b1;
    @(negedge clk);
    check({tag, " valid"}, int'(out_valid), 1);
    check({tag, " cb"}, int'(out_cb), ecb);
    check({tag, " cr"}, int'(out_cr), ecr);
  endtask

  task automatic run_line(input logic [25:0] v);
    for (int i = 0; i < int'(v[20:16]); i++)
      send(i == 0, v[25:24], v[23], v[22], v[21],
           (int'(v[15:8]) + 7 * i) % 256, (int'(v[7:0]) + 256 - 5 * i) % 256, prev_dis);
    prev_dis = v[22] || v[21] || v[25:24] == 2'd3;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < LEN; i++) begin m_cb[i] = 0; m_cr[i] = 0; end
    @(negedge clk); @(negedge clk);
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset cb", int'(out_cb), 0);
    check("R1 reset cr", int'(out_cr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release valid", int'(out_valid), 0);
    check("R1 after release cb", int'(out_cb), 0);

    for (int k = 0; k < NV; k++) run_line(VEC[k]);

    // R2: idle cycles hold the outputs
    begin
      int hcb, hcr;
      hcb = int'(out_cb); hcr = int'(out_cr);
      in_valid = 1'b0; in_cb = 8'h00; in_cr = 8'hFF; line_start = 1'b0;
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        check("R2 idle valid", int'(out_valid), 0);
        check("R2 idle cb hold", int'(out_cb), hcb);
        check("R2 idle cr hold", int'(out_cr), hcr);
      end
    end

    // R9: reset mid-run discards history
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset valid", int'(out_valid), 0);
    check("R1 mid reset cb", int'(out_cb), 0);
    rst_n = 1'b1;
    m_seen = 1'b0; m_hist = 1'b0; m_wp = 0;
    @(negedge clk);
    run_line({2'd0, 1'b0, 1'b0, 1'b0, 5'd16, 8'h55, 8'hAA});
    run_line({2'd0, 1'b0, 1'b0, 1'b0, 5'd16, 8'hFF, 8'h00});
    in_valid = 1'b0; line_start = 1'b0;
    @(negedge clk);
    check("R2 last valid drop", int'(out_valid), 0);
    summary();
  end

endmodule